// File: doc/BRIEF.md
# Interval Timer with Millisecond Prescaler

This block is a periodic interval timer that sits on an 8-bit register bus. Software writes an interval value N into one register. The block then counts N+1 base units and raises a one-clock interrupt pulse. It reloads on its own and repeats. The count moves only when an externally supplied one-microsecond strobe arrives, so the block never builds its own time base.

A build-time switch can place a millisecond prescaler in front of the counter. With the prescaler, the 8-bit interval covers 1 to 256 ms instead of 1 to 256 µs. Software cannot turn the prescaler on or off.

A write to the interval register takes effect at once. It reloads the counter and clears the prescaler phase, so no interrupt left over from the old interval can fire. A second build-time switch can guard the write path. When that switch is set, writes are accepted only while an external privilege flag is high.

Top module: `tmr_interval`

## Requirements
- R1: After a synchronous active-high reset, the interval register reads 0x00 and `irq_pulse` stays low, whatever the ticks, until the first accepted interval write.
- R2: With `bus_rd` high and `bus_addr` equal to REG_ADDR (default 0), `bus_rdata` returns the programmed interval in the same cycle. With any other address, or with `bus_rd` low, it returns 0x00.
- R3: For an interval value N, the first interrupt comes on the (N+1)th base unit after the write. Later interrupts follow every N+1 base units, because the counter reloads by itself. So 0x00 gives a period of 1 unit and 0xFF gives 256.
- R4: The interrupt is high for exactly the one clock after the clock edge that samples the expiring base unit.
- R5: The count moves only on base units. Clocks without a tick change nothing, and ticks spaced irregularly still count one unit each.
- R6: An accepted interval write restarts the count on the same edge and clears the prescaler phase. It discards the old count, so no interrupt from that count follows.
- R7: With WRITE_PROTECT=1, a write while `priv_flag` is low is ignored. Both the register value and the running count stay untouched.
- R8: With WRITE_PROTECT=0, writes are accepted whatever the level of `priv_flag`.
- R9: With MS_EN=1, one base unit is US_PER_MS microsecond ticks (default 1000). With MS_EN=0, one base unit is one tick.
- R10: A write whose `bus_addr` differs from REG_ADDR has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| priv_flag | input | 1 | Privilege level that permits writes when write protection is built in |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_pulse | output | 1 | One-clock interrupt on each expiry |

## Verification
The main timing path is tried with several intervals:
- Interval 0 with back-to-back ticks separates "every tick" from an off-by-one period.
- Interval 3 with ticks spaced irregularly shows that only ticks advance the count.
- Interval 255 probes the top of the range and the automatic reload.

Rewrites in the middle of a count separate an immediate restart from waiting for expiry. Writes without privilege and writes to a wrong address show that the running schedule is left alone. A second instance, built with the prescaler and without write protection, checks the units-per-base-unit ratio and that the prescaler phase is cleared on rewrite.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // width able to hold 0 .. n-1, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // write gate: protection off accepts everything
  function automatic logic write_allowed(input logic protect_en, input logic priv);
    return !protect_en || priv;
  endfunction

  // down-counter expiry test
  function automatic logic expired(input logic [7:0] cnt);
    return cnt == 8'd0;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int REG_ADDR      = 0,
  parameter bit WRITE_PROTECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              priv_flag,
  output logic [DATA_W-1:0] interval_q,
  output logic              wr_accept,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit;

  assign hit       = bus_addr == ADDR_W'(REG_ADDR);
  assign wr_accept = bus_wr && hit && tmr_pkg::write_allowed(WRITE_PROTECT, priv_flag);

  always_ff @(posedge clk) begin
    if (rst)            interval_q <= '0;
    else if (wr_accept) interval_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) bus_rdata = interval_q;
  end

  // R10: a miss on the address leaves the register alone
  a_r10_addr_miss: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> $stable(interval_q));

  generate
    if (WRITE_PROTECT) begin : g_prot_chk
      // R7
      a_r7_unprivileged: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !priv_flag) |=> $stable(interval_q));
    end
  endgenerate
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter bit MS_EN     = 1'b0,
  parameter int US_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic us_tick,
  output logic base_tick
);
  localparam int PW = tmr_pkg::idx_w(US_PER_MS);

  generate
    if (MS_EN) begin : g_ms
      logic [PW-1:0] pre_q;
      logic          wrap;

      assign wrap      = pre_q == PW'(US_PER_MS - 1);
      assign base_tick = us_tick && wrap;

      always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else if (us_tick)   pre_q <= wrap ? '0 : pre_q + 1'b1;
      end

      // R9: the phase stays inside one millisecond
      a_r9_phase_range: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PW'(US_PER_MS - 1));
      // R6: rewrite clears the phase
      a_r6_phase_clear: assert property (@(posedge clk) disable iff (rst)
        restart |=> pre_q == '0);
    end else begin : g_us
      logic unused_restart;
      assign unused_restart = restart;
      assign base_tick      = us_tick;
    end
  endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              base_tick,
  output logic [DATA_W-1:0] cnt_q,
  output logic              armed,
  output logic              irq
);
  logic hit_zero;
  assign hit_zero = tmr_pkg::expired(8'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (armed && base_tick) begin
        if (hit_zero) begin
          cnt_q <= reload_val;
          irq   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R1
  a_r1_needs_arm: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(armed));
  // R5
  a_r5_after_tick: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(base_tick));
  // R3
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt_q == reload_val);
  // R6
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val) && !irq));
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int REG_ADDR      = 0,
  parameter bit MS_EN         = 1'b0,
  parameter int US_PER_MS     = 1000,
  parameter bit WRITE_PROTECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              priv_flag,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);
  logic [DATA_W-1:0] interval_q;
  logic [DATA_W-1:0] cnt_q;
  logic              wr_accept;
  logic              base_tick;
  logic              armed;

  tmr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WRITE_PROTECT(WRITE_PROTECT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .priv_flag(priv_flag), .interval_q(interval_q),
    .wr_accept(wr_accept), .bus_rdata(bus_rdata)
  );

  tmr_prescale #(.MS_EN(MS_EN), .US_PER_MS(US_PER_MS)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_accept), .us_tick(us_tick), .base_tick(base_tick)
  );

  tmr_count #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_accept), .load_val(bus_wdata), .reload_val(interval_q),
    .base_tick(base_tick), .cnt_q(cnt_q), .armed(armed), .irq(irq_pulse)
  );

  // R4: the pulse belongs to a single expiry
  a_r4_single_expiry: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(armed && base_tick && !wr_accept));
endmodule

// File: tb/tmr_interval_test.sv
module tmr_interval_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b0, priv_flag = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pulse;

  logic       m_tick = 1'b0, m_wr = 1'b0, m_rd = 1'b0;
  logic [7:0] m_wdata = '0;
  logic [7:0] m_rdata;
  logic       m_irq;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  int remaining = 0, period = 0;
  bit armed_m = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_interval uut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .priv_flag(priv_flag), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  tmr_interval #(.MS_EN(1'b1), .US_PER_MS(5), .WRITE_PROTECT(1'b0)) uut_ms (
    .clk(clk), .rst(rst), .us_tick(m_tick), .priv_flag(1'b0), .bus_addr(2'd0),
    .bus_wr(m_wr), .bus_wdata(m_wdata), .bus_rd(m_rd), .bus_rdata(m_rdata),
    .irq_pulse(m_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: each irq must match the head of the expected queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (irq_pulse) begin
        if (exp_q.size() == 0) check(1'b0, "R1/R3 unexpected irq at cycle", cyc, -1);
        else begin
          check(exp_q[0] == cyc, "R3/R4 irq cycle", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
        check(1'b0, "R3/R5 missing irq at cycle", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // driver tasks start and end just after a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic tick();
    us_tick = 1'b1;
    if (armed_m) begin
      remaining--;
      if (remaining == 0) begin
        exp_q.push_back(cyc + 1);
        remaining = period;
      end
    end
    @(posedge clk); @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d, input logic p);
    bus_addr = a; bus_wdata = d; priv_flag = p; bus_wr = 1'b1;
    if (a == 2'd0 && p) begin
      period = int'(d) + 1; remaining = period; armed_m = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; priv_flag = 1'b0; bus_addr = '0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic rd, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = rd; #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state and no irq before any write
    read_chk(2'd0, 1'b1, 8'h00, "R1 reset interval");
    for (int i = 0; i < 20; i++) tick();
    // R7 unprivileged write ignored
    write(2'd0, 8'h05, 1'b0);
    read_chk(2'd0, 1'b1, 8'h00, "R7 blocked write");
    for (int i = 0; i < 10; i++) tick();
    // R3 interval 0: every tick expires
    write(2'd0, 8'h00, 1'b1);
    read_chk(2'd0, 1'b1, 8'h00, "R2 readback 0");
    for (int i = 0; i < 6; i++) tick();
    // R5 interval 3 with irregular gaps
    write(2'd0, 8'h03, 1'b1);
    read_chk(2'd0, 1'b1, 8'h03, "R2 readback 3");
    read_chk(2'd1, 1'b1, 8'h00, "R2 other address reads zero");
    read_chk(2'd0, 1'b0, 8'h00, "R2 no read enable reads zero");
    for (int i = 0; i < 12; i++) begin tick(); idle(i % 3); end
    // R6 restart mid count: 2 ticks into interval 3, rewrite 4
    tick(); tick();
    write(2'd0, 8'h04, 1'b1);
    for (int i = 0; i < 11; i++) tick();
    // R7 unprivileged write mid count leaves schedule
    tick();
    write(2'd0, 8'h00, 1'b0);
    read_chk(2'd0, 1'b1, 8'h04, "R7 value kept");
    for (int i = 0; i < 9; i++) tick();
    // R10 write to other address ignored
    write(2'd2, 8'h01, 1'b1);
    read_chk(2'd0, 1'b1, 8'h04, "R10 value kept");
    for (int i = 0; i < 7; i++) tick();
    // R3 top of range
    write(2'd0, 8'hFF, 1'b1);
    read_chk(2'd0, 1'b1, 8'hFF, "R2 readback FF");
    for (int i = 0; i < 520; i++) tick();
    idle(3);
    check(exp_q.size() == 0, "R3 all expected irqs seen", exp_q.size(), 0);

    // prescaled instance: R8 write without privilege, R9 five ticks per unit
    m_wdata = 8'h01; m_wr = 1'b1; @(posedge clk); @(negedge clk); m_wr = 1'b0;
    m_rd = 1'b1; #1;
    check(m_rdata == 8'h01, "R8 unguarded write accepted", m_rdata, 1);
    m_rd = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      m_tick = 1'b1; @(posedge clk); @(negedge clk); m_tick = 1'b0;
      check(m_irq == (i == 10), "R9 prescaled period", m_irq, (i == 10));
    end
    // R6 rewrite clears prescaler phase (phase now 2)
    m_wdata = 8'h00; m_wr = 1'b1; @(posedge clk); @(negedge clk); m_wr = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      m_tick = 1'b1; @(posedge clk); @(negedge clk); m_tick = 1'b0;
      check(m_irq == (i == 5), "R6 phase restart", m_irq, (i == 5));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule